// File: doc/BRIEF.md
# Five-Stage Tile Pipeline Sequencer

This block drives the tiles of one layer through a fixed chain of five shared accelerator stages: fetch into on-chip memory, 3x3 depthwise compute, 1x1 pointwise compute, pooling, and store back to external memory. Each stage unit is a separate datapath. The sequencer gives it a one-cycle start pulse together with the tile number and the buffer bank it must use. The unit answers with a one-cycle done pulse when it has finished that tile. The sequencer contains no datapath of its own. It only decides when each stage may begin its next tile.

Two double-buffered bank pairs surround the compute chain. One pair sits between the fetch stage and the depthwise stage. The other sits between the pooling stage and the store stage. Tile n uses bank n mod 2 on both sides, so fetching tile n+1 and storing tile n-1 can run while tile n is computed. The two hand-offs between compute stages each go through a single on-chip buffer and never touch external memory. The same stages are reused for every layer. Software starts a layer with a tile count. When the last tile has been stored, the block gives a one-cycle layer-complete pulse.

Top module: `tile_pipe_ctrl`

## Requirements
- R1: While reset is held and after it is released, `layer_busy_o`, `layer_done_o`, `stage_start_o` and `stage_bank_o` are all zero. Reset is synchronous and active-high.
- R2: Stage indices are 0 for fetch, 1 for depthwise, 2 for pointwise, 3 for pool and 4 for store. Every stage starts tiles 0 to N-1 exactly once each, in ascending order, and `stage_tile_o[s]` shows the tile number. A stage s>0 starts tile n only after stage s-1 has signalled done for tile n.
- R3: A stage starts a new tile only after it has signalled done for its previous tile. Every start is a single-cycle pulse.
- R4: The fetch stage starts tile n only after the depthwise stage has signalled done for tile n-2. For every stage, `stage_bank_o[s]` equals bit 0 of the tile it was started on.
- R5: The pool stage starts tile n only after the store stage has signalled done for tile n-2.
- R6: The depthwise stage starts tile n only after the pointwise stage has finished tile n-1. The pointwise stage starts tile n only after the pool stage has finished tile n-1.
- R7: Stages run at the same time. Fetch and store both make progress while a compute stage is busy on another tile.
- R8: `layer_done_o` is high for exactly one cycle. That cycle is the one after the edge that takes in the store-done of the last tile. `layer_busy_o` is low in that same cycle.
- R9: A layer started with a tile count of zero gives `layer_done_o` in the cycle after the accepting edge and issues no stage start.
- R10: A layer of a single tile runs that tile through all five stages and completes.
- R11: A `layer_start_i` seen while `layer_busy_o` is high is ignored, and the running layer keeps its tile count.
- R12: A `stage_done_i` pulse for a stage that has no tile in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| layer_start_i | input | 1 | Request to begin a layer; accepted only while idle |
| tile_count_i | input | TILE_W | Number of tiles in the layer |
| layer_busy_o | output | 1 | A layer is in progress |
| layer_done_o | output | 1 | One-cycle pulse when the layer has completed |
| stage_start_o | output | 5 | One start pulse per stage |
| stage_done_i | input | 5 | One done pulse per stage |
| stage_tile_o | output | 5 x TILE_W | Tile number given to each stage at its start |
| stage_bank_o | output | 5 | Bank select for each stage (tile parity) |

## Verification
Wrong per-stage progress counts show up at the ports as a start that comes too early. Such a start has the wrong tile number, overtakes its upstream stage, or claims a bank that a neighbour is still using. The bench flags this on the first start after the fault, because it checks every start against the done pulses it has already counted. A wrong layer count or a lost done shows up as a missing, duplicated or mistimed `layer_done_o`, checked to the exact cycle. A stage unit that never answers stalls the layer, and the bounded waits report this.

// File: rtl/tile_pipe_pkg.sv
package tile_pipe_pkg;

    localparam int NSTG = 5;

    typedef enum logic [2:0] {
        ST_LOAD = 3'd0,
        ST_DW   = 3'd1,
        ST_PW   = 3'd2,
        ST_POOL = 3'd3,
        ST_WB   = 3'd4
    } stage_e;

    typedef enum logic {
        LY_IDLE = 1'b0,
        LY_RUN  = 1'b1
    } layer_st_e;

    // Number of tiles the buffer downstream of a stage can hold.
    function automatic int unsigned buf_slots(input int s);
        case (s)
            int'(ST_LOAD): buf_slots = 2;
            int'(ST_DW):   buf_slots = 1;
            int'(ST_PW):   buf_slots = 1;
            int'(ST_POOL): buf_slots = 2;
            default:       buf_slots = 0;
        endcase
    endfunction

endpackage

// File: rtl/tpc_stage.sv
module tpc_stage #(
    parameter int CW = 8
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          clear_i,
    input  logic          go_i,
    input  logic          done_i,
    output logic          start_o,
    output logic          busy_o,
    output logic [CW-1:0] issued_o,
    output logic [CW-1:0] completed_o,
    output logic [CW-1:0] tile_o,
    output logic          bank_o
);
    logic          start_q;
    logic          busy_q;
    logic [CW-1:0] issued_q;
    logic [CW-1:0] completed_q;
    logic [CW-1:0] tile_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clear_i) begin
            start_q     <= 1'b0;
            busy_q      <= 1'b0;
            issued_q    <= '0;
            completed_q <= '0;
            tile_q      <= '0;
        end else begin
            start_q <= go_i;
            if (go_i) begin
                busy_q   <= 1'b1;
                tile_q   <= issued_q;
                issued_q <= issued_q + CW'(1);
            end else if (done_i && busy_q) begin
                busy_q      <= 1'b0;
                completed_q <= completed_q + CW'(1);
            end
        end
    end

    assign start_o     = start_q;
    assign busy_o      = busy_q;
    assign issued_o    = issued_q;
    assign completed_o = completed_q;
    assign tile_o      = tile_q;
    assign bank_o      = tile_q[0];
endmodule

// File: rtl/tpc_layer.sv
module tpc_layer
    import tile_pipe_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          start_i,
    input  logic [CW-1:0] count_i,
    input  logic          wb_fire_i,
    input  logic [CW-1:0] wb_completed_i,
    output logic          running_o,
    output logic [CW-1:0] count_o,
    output logic          accept_o,
    output logic          done_o
);
    layer_st_e     st_q;
    logic [CW-1:0] count_q;
    logic          done_q;
    logic          last_tile;

    assign accept_o  = start_i && (st_q == LY_IDLE);
    assign last_tile = (st_q == LY_RUN) && wb_fire_i &&
                       ((wb_completed_i + CW'(1)) == count_q);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q    <= LY_IDLE;
            count_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                LY_IDLE: begin
                    if (start_i) begin
                        if (count_i == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            st_q    <= LY_RUN;
                            count_q <= count_i;
                        end
                    end
                end
                default: begin
                    if (last_tile) begin
                        done_q <= 1'b1;
                        st_q   <= LY_IDLE;
                    end
                end
            endcase
        end
    end

    assign running_o = (st_q == LY_RUN);
    assign count_o   = count_q;
    assign done_o    = done_q;
endmodule

// File: rtl/tile_pipe_ctrl.sv
module tile_pipe_ctrl
    import tile_pipe_pkg::*;
#(
    parameter int TILE_W = 8
) (
    input  logic                               clk_i,
    input  logic                               rst_i,
    input  logic                               layer_start_i,
    input  logic [TILE_W-1:0]                  tile_count_i,
    output logic                               layer_busy_o,
    output logic                               layer_done_o,
    output logic [NSTG-1:0]                    stage_start_o,
    input  logic [NSTG-1:0]                    stage_done_i,
    output logic [NSTG-1:0][TILE_W-1:0]        stage_tile_o,
    output logic [NSTG-1:0]                    stage_bank_o
);
    localparam int LAST = int'(ST_WB);

    logic [TILE_W-1:0] issued    [NSTG];
    logic [TILE_W-1:0] completed [NSTG];
    logic [NSTG-1:0]   stage_busy;
    logic [NSTG-1:0]   go;
    logic              running;
    logic              accept;
    logic [TILE_W-1:0] count_q;

    tpc_layer #(.CW(TILE_W)) u_layer (
        .clk_i          (clk_i),
        .rst_i          (rst_i),
        .start_i        (layer_start_i),
        .count_i        (tile_count_i),
        .wb_fire_i      (stage_done_i[LAST] && stage_busy[LAST]),
        .wb_completed_i (completed[LAST]),
        .running_o      (running),
        .count_o        (count_q),
        .accept_o       (accept),
        .done_o         (layer_done_o)
    );

    for (genvar s = 0; s < NSTG; s++) begin : g_stage
        localparam logic [TILE_W-1:0] SLOTS = TILE_W'(buf_slots(s));
        logic pred_ok;
        logic room_ok;

        if (s == 0) begin : g_head
            assign pred_ok = 1'b1;
        end else begin : g_follow
            assign pred_ok = completed[s-1] > issued[s];
        end

        if (s == NSTG - 1) begin : g_tail
            assign room_ok = 1'b1;
        end else begin : g_feed
            assign room_ok = (issued[s] - completed[s+1]) < SLOTS;
        end

        assign go[s] = running && !stage_busy[s] && (issued[s] < count_q) &&
                       pred_ok && room_ok;

        tpc_stage #(.CW(TILE_W)) u_stage (
            .clk_i       (clk_i),
            .rst_i       (rst_i),
            .clear_i     (accept),
            .go_i        (go[s]),
            .done_i      (stage_done_i[s]),
            .start_o     (stage_start_o[s]),
            .busy_o      (stage_busy[s]),
            .issued_o    (issued[s]),
            .completed_o (completed[s]),
            .tile_o      (stage_tile_o[s]),
            .bank_o      (stage_bank_o[s])
        );
    end

    assign layer_busy_o = running;
endmodule

// File: rtl/tpc_checker.sv
module tpc_checker
    import tile_pipe_pkg::*;
(
    input logic            clk_i,
    input logic            rst_i,
    input logic [NSTG-1:0] stage_start_i,
    input logic [NSTG-1:0] stage_busy_i,
    input logic [NSTG-1:0] stage_bank_i,
    input logic            layer_busy_i,
    input logic            layer_done_i
);
    for (genvar s = 0; s < NSTG; s++) begin : g_pulse
        AST_START_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
            stage_start_i[s] |=> !stage_start_i[s]); // R3
    end

    AST_IN_BANK_EXCL: assert property (@(posedge clk_i) disable iff (rst_i)
        (stage_busy_i[0] && stage_busy_i[1]) |-> (stage_bank_i[0] != stage_bank_i[1])); // R4

    AST_OUT_BANK_EXCL: assert property (@(posedge clk_i) disable iff (rst_i)
        (stage_busy_i[3] && stage_busy_i[4]) |-> (stage_bank_i[3] != stage_bank_i[4])); // R5

    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
        layer_done_i |=> !layer_done_i); // R8

    AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        layer_done_i |-> !layer_busy_i); // R8

    AST_NO_START_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        (stage_start_i != '0) |-> layer_busy_i); // R9
endmodule

bind tile_pipe_ctrl tpc_checker u_chk (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .stage_start_i (stage_start_o),
    .stage_busy_i  (stage_busy),
    .stage_bank_i  (stage_bank_o),
    .layer_busy_i  (layer_busy_o),
    .layer_done_i  (layer_done_o)
);

// File: tb/tile_pipe_ctrl_tb_top.sv
module tile_pipe_ctrl_tb_top;
    localparam int TW = 8;
    localparam int NS = 5;
    localparam int SLOTS [NS] = '{2, 1, 1, 2, 0};
    // {tile count, max stage latency}
    localparam int TBL [6][2] = '{'{5, 1}, '{8, 6}, '{3, 12}, '{12, 3}, '{2, 20}, '{16, 2}};

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                     rst;
    logic                     layer_start;
    logic [TW-1:0]            tile_count;
    logic                     layer_busy;
    logic                     layer_done;
    logic [NS-1:0]            stage_start;
    logic [NS-1:0]            done_vec;
    logic [NS-1:0]            spur;
    logic [NS-1:0][TW-1:0]    stage_tile;
    logic [NS-1:0]            stage_bank;
    int                       maxlat;

    tile_pipe_ctrl #(.TILE_W(TW)) dut_i (
        .clk_i         (clk),
        .rst_i         (rst),
        .layer_start_i (layer_start),
        .tile_count_i  (tile_count),
        .layer_busy_o  (layer_busy),
        .layer_done_o  (layer_done),
        .stage_start_o (stage_start),
        .stage_done_i  (done_vec),
        .stage_tile_o  (stage_tile),
        .stage_bank_o  (stage_bank)
    );

    // Stage unit models with random latency
    for (genvar s = 0; s < NS; s++) begin : g_model
        logic md = 1'b0;
        assign done_vec[s] = md | spur[s];
        initial begin
            forever begin
                @(negedge clk);
                if (stage_start[s]) begin
                    int lat;
                    lat = 1 + int'($urandom % 32'(maxlat + s));
                    repeat (lat - 1) @(negedge clk);
                    md = 1'b1;
                    @(negedge clk);
                    md = 1'b0;
                end
            end
        end
    end

    // Monitor: own progress counts built from port activity
    int scnt [NS];
    int dcnt [NS];
    int dprev [NS];
    int mchk = 0, mfail = 0, ndone = 0, ov_load = 0, ov_wb = 0;
    int cur_count = 0;
    bit exp_done = 1'b0;

    task automatic mcheck(input bit ok, input string req, input int act, input int exp);
        mchk++;
        if (!ok) begin
            mfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NS; s++) begin scnt[s] = 0; dcnt[s] = 0; dprev[s] = 0; end
            exp_done = 1'b0;
        end else begin
            if (layer_done) begin
                mcheck(exp_done, "R8", 1, int'(exp_done));
                mcheck(!layer_busy, "R8", int'(layer_busy), 0);
                ndone++;
            end else if (exp_done) begin
                mcheck(1'b0, "R8", 0, 1);
            end
            exp_done = 1'b0;
            for (int s = 0; s < NS; s++) begin
                if (stage_start[s]) begin
                    int t;
                    t = scnt[s];
                    mcheck(t < cur_count, "R2", t, cur_count - 1);
                    mcheck(int'(stage_tile[s]) == t, "R2", int'(stage_tile[s]), t);
                    mcheck(stage_bank[s] == t[0], "R4", int'(stage_bank[s]), int'(t[0]));
                    mcheck(dprev[s] == t, "R3", dprev[s], t);
                    if (s > 0) mcheck(dprev[s-1] > t, "R2", dprev[s-1], t + 1);
                    if (s < NS - 1)
                        mcheck(t - dprev[s+1] < SLOTS[s], (s == 0) ? "R4" : (s == 3) ? "R5" : "R6",
                               dprev[s+1], t - SLOTS[s] + 1);
                    scnt[s] = t + 1;
                end
            end
            for (int s = 0; s < NS; s++) dprev[s] = dcnt[s];
            for (int s = 0; s < NS; s++) begin
                if (done_vec[s] && scnt[s] > dcnt[s]) begin
                    dcnt[s]++;
                    if (s == NS - 1 && dcnt[s] == cur_count) exp_done = 1'b1;
                end
            end
            if (scnt[0] > dcnt[0] && (scnt[1] > dcnt[1] || scnt[2] > dcnt[2] || scnt[3] > dcnt[3])) ov_load++;
            if (scnt[4] > dcnt[4] && (scnt[1] > dcnt[1] || scnt[2] > dcnt[2] || scnt[3] > dcnt[3])) ov_wb++;
            if (layer_start && !layer_busy) begin
                cur_count = int'(tile_count);
                for (int s = 0; s < NS; s++) begin scnt[s] = 0; dcnt[s] = 0; dprev[s] = 0; end
                if (tile_count == '0) exp_done = 1'b1;
            end
        end
    end

    // Directed checks
    int checks = 0, fails = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic launch(input int cnt);
        @(negedge clk);
        layer_start = 1'b1;
        tile_count  = TW'(cnt);
        @(negedge clk);
        layer_start = 1'b0;
    endtask

    task automatic wait_done(input int d0);
        for (int c = 0; c < 20000 && ndone == d0; c++) @(negedge clk);
        check(ndone == d0 + 1, "R8", ndone - d0, 1);
    endtask

    task automatic check_counts(input int cnt, input string req);
        for (int s = 0; s < NS; s++) begin
            check(scnt[s] == cnt && dcnt[s] == cnt, req, scnt[s], cnt);
        end
    endtask

    task automatic run_layer(input int cnt, input string req);
        int d0;
        d0 = ndone;
        launch(cnt);
        wait_done(d0);
        @(negedge clk);
        check_counts(cnt, req);
    endtask

    initial begin
        rst = 1'b1;
        layer_start = 1'b0;
        tile_count = '0;
        spur = '0;
        maxlat = 1;
        repeat (3) @(negedge clk);
        check(!layer_busy && !layer_done && stage_start == '0 && stage_bank == '0, "R1",
              int'({layer_busy, layer_done, stage_start, stage_bank}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!layer_busy && stage_start == '0, "R1", int'({layer_busy, stage_start}), 0);

        // Table-driven layers: R2 ordering with varied counts and latencies
        for (int i = 0; i < 6; i++) begin
            maxlat = TBL[i][1];
            run_layer(TBL[i][0], "R2");
        end
        check(ov_load > 0, "R7", ov_load, 1);
        check(ov_wb > 0, "R7", ov_wb, 1);

        // R9: zero tiles
        begin
            int d0;
            d0 = ndone;
            @(negedge clk);
            layer_start = 1'b1;
            tile_count  = '0;
            @(negedge clk);
            layer_start = 1'b0;
            check(layer_done && !layer_busy, "R9", int'({layer_done, layer_busy}), 2);
            @(negedge clk);
            check(!layer_done && stage_start == '0, "R9", int'({layer_done, stage_start}), 0);
            check(ndone == d0 + 1, "R9", ndone - d0, 1);
        end

        // R10: single tile
        maxlat = 4;
        run_layer(1, "R10");

        // R11: start while busy ignored
        begin
            int d0;
            d0 = ndone;
            maxlat = 8;
            launch(3);
            repeat (6) @(negedge clk);
            check(layer_busy, "R11", int'(layer_busy), 1);
            layer_start = 1'b1;
            tile_count  = TW'(9);
            @(negedge clk);
            layer_start = 1'b0;
            wait_done(d0);
            @(negedge clk);
            check_counts(3, "R11");
        end

        // R12: stray done pulses while idle
        spur = '1;
        @(negedge clk);
        spur = '0;
        check(!layer_done && !layer_busy && stage_start == '0, "R12",
              int'({layer_done, layer_busy, stage_start}), 0);
        @(negedge clk);
        check(!layer_done && stage_start == '0, "R12", int'({layer_done, stage_start}), 0);

        // R12: stray done pulses during a layer to idle stages
        begin
            int d0;
            int inj;
            d0 = ndone;
            inj = 0;
            maxlat = 10;
            launch(4);
            for (int c = 0; c < 3000 && ndone == d0 && inj < 4; c++) begin
                @(negedge clk);
                if (layer_busy && scnt[2] > 0 && scnt[2] == dcnt[2] && !stage_start[2] && scnt[2] < 4) begin
                    spur[2] = 1'b1;
                    @(negedge clk);
                    spur[2] = 1'b0;
                    inj++;
                end
            end
            check(inj > 0, "R12", inj, 1);
            wait_done(d0);
            @(negedge clk);
            check_counts(4, "R12");
        end

        repeat (5) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks + mchk, fails + mfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL R8 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks + mchk + 1, fails + mfail + 1);
        $finish;
    end
endmodule